// File: doc/BRIEF.md
# Streaming Forward Lifting Wavelet Transform (one dimension)

The block takes a stream of signed fixed-point samples, one even/odd pair per beat, and produces one low-band and one high-band coefficient per pair. It uses a six-step lifting factorisation in which predict steps and update steps alternate. A predict step corrects each odd sample using the even samples on either side of it. An update step corrects each even sample using the odd samples on either side of it. A final stage scales each band by its own factor. All six lifting coefficients, the two scale factors and the number of fraction bits are parameters.

Each lifting step multiplies both neighbours by its coefficient in parallel, registers the two products, and then adds them in the next cycle. As a result, no register-to-register path contains more than one multiplier. A predict step must see the next pair before it can finish the current one, so each of the three predict steps holds back one pair. At the edges of a sequence the block uses whole-sample mirroring. A start flag on the first pair mirrors the missing left neighbour. Flush beats after the last pair mirror the missing right neighbour and drain the pairs still held inside.

Top module: `wavelet_lift_fwd`

## Requirements
- R1: A beat with `in_valid` high and `in_flush` low carries sample x[2n] on `in_even` and sample x[2n+1] on `in_odd`. Pairs are consumed in arrival order, and idle cycles between beats have no effect on the results.
- R2: Let s0=x[2n] and d0=x[2n+1]. Steps 0, 2 and 4 are predict steps: d += R(k·(s[n]+s[n+1])). Steps 1, 3 and 5 are update steps: s += R(k·(d[n-1]+d[n])). Each step uses its own coefficient k, taken from STEP0_K to STEP5_K.
- R3: `out_low` = R(SCALE_LO·s) and `out_high` = R(SCALE_HI·d), computed on the values left by step 5.
- R4: R(p) = (p + 2^(FRAC-1)) >>> FRAC. Here p is the exact product of a coefficient and a sum, and the result is truncated to the internal width.
- R5: On the pair marked by `in_start`, every update step uses d[0] in place of the missing d[-1].
- R6: On the last pair of a sequence, every predict step uses s[last] in place of the missing s[last+1].
- R7: A beat with `in_flush` high is a flush beat and carries no data, even when `in_valid` is also high. Three flush beats drain every pending pair. Any extra flush beats produce no output. A sequence of M pairs yields exactly M outputs.
- R8: `out_valid` for pair n is asserted on the 14th rising edge, counting from the edge that samples the beat after pair n+3 arrives, or the matching flush beat. No output appears earlier.
- R9: While reset is asserted, and after it is released until the first result, `out_valid` is low.
- R10: An input sequence whose samples all share one value yields identical low coefficients at every position, edges included, and likewise identical high coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Data beat qualifier |
| in_start | input | 1 | Marks the first pair of a sequence |
| in_flush | input | 1 | Flush beat after the last pair |
| in_even | input | DW | Even-indexed sample, signed |
| in_odd | input | DW | Odd-indexed sample, signed |
| out_valid | output | 1 | Result qualifier |
| out_low | output | DW+GUARD | Low-band coefficient, signed |
| out_high | output | DW+GUARD | High-band coefficient, signed |

## Verification
The hardest case to reach is a pair that is still held in all three predict steps when the sequence ends. That pair only leaves the block through the chain of flush beats, and it depends on the mirrored right neighbour being applied at each stage. The stimulus table therefore ends every sequence with flush beats, and it varies the sequence length down to a single pair. It also adds idle gaps between beats, sends surplus flush beats, and sends flush beats with `in_valid` also high and junk data on the sample inputs. Every result is compared with a mirrored-edge model of the same rounded lifting equations.

// File: rtl/wl_lift_pkg.sv
package wl_lift_pkg;

  // number of lifting steps in the factorisation
  localparam int LIFT_STEPS = 6;

  // predict refines odd samples from even neighbours; update refines even
  // samples from odd neighbours
  typedef enum logic {
    STEP_PREDICT = 1'b0,
    STEP_UPDATE  = 1'b1
  } step_kind_e;

endpackage

// File: rtl/wl_lift_step.sv
module wl_lift_step
  import wl_lift_pkg::*;
#(
  parameter int         W    = 16,
  parameter int         CW   = 16,
  parameter int         FRAC = 12,
  parameter int         COEF = 0,
  parameter step_kind_e KIND = STEP_PREDICT
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                in_vld,
  input  logic                in_fl,
  input  logic                in_first,
  input  logic signed [W-1:0] in_s,
  input  logic signed [W-1:0] in_d,
  output logic                out_vld,
  output logic                out_fl,
  output logic                out_first,
  output logic signed [W-1:0] out_s,
  output logic signed [W-1:0] out_d
);

  localparam int PW = W + CW;
  localparam int SW = PW + 1;
  localparam logic signed [CW-1:0] KV   = CW'(COEF);
  localparam logic signed [SW-1:0] HALF = SW'(1) << (FRAC - 1);

  // operand selection (filled by the variant below)
  logic                emit, emit_fl, sel_first;
  logic signed [W-1:0] sel_u, sel_v, sel_base, sel_pass;

  // product stage
  logic                a_vld, a_fl, a_first;
  logic signed [W-1:0] a_base, a_pass;
  logic signed [PW-1:0] a_pu, a_pv;
  logic signed [PW-1:0] pu_c, pv_c;

  // sum stage
  logic signed [SW-1:0] sum_c;
  logic signed [W-1:0]  rnd_c, new_c, b_s_n, b_d_n;

  generate
    if (KIND == STEP_PREDICT) begin : g_pred
      logic                h_full, h_full_n, h_first, h_load;
      logic signed [W-1:0] h_s, h_d;

      always_comb begin
        emit      = in_vld & (h_full | in_fl);
        emit_fl   = in_vld & in_fl & ~h_full;
        sel_u     = h_s;
        sel_v     = in_fl ? h_s : in_s;   // mirror at the right edge
        sel_base  = h_d;
        sel_pass  = h_s;
        sel_first = h_first;
        h_load    = in_vld & ~in_fl;
        h_full_n  = in_vld ? ~in_fl : h_full;
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) h_full <= 1'b0;
        else         h_full <= h_full_n;
      end

      always_ff @(posedge clk) begin
        if (h_load) begin
          h_s     <= in_s;
          h_d     <= in_d;
          h_first <= in_first;
        end
      end

      // R6
      drain_emit_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (in_vld && in_fl && h_full) |=> (a_vld && !a_fl && a_pu == a_pv));

      // R7
      empty_flush_pass_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (in_vld && in_fl && !h_full) |=> (a_vld && a_fl));

      // R1
      first_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (in_vld && !in_fl && !h_full) |=> !a_vld);
    end else begin : g_upd
      logic                p_load;
      logic signed [W-1:0] d_prev;

      always_comb begin
        emit      = in_vld;
        emit_fl   = in_fl;
        sel_u     = in_first ? in_d : d_prev;  // mirror at the left edge
        sel_v     = in_d;
        sel_base  = in_s;
        sel_pass  = in_d;
        sel_first = in_first;
        p_load    = in_vld & ~in_fl;
      end

      always_ff @(posedge clk) begin
        if (p_load) d_prev <= in_d;
      end

      // R5
      start_mirror_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (in_vld && !in_fl && in_first) |=> (a_pu == a_pv));

      // R2
      one_per_beat_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        in_vld |=> a_vld);
    end
  endgenerate

  // both multiplies run side by side; each is the only logic on its path
  assign pu_c = PW'(sel_u) * PW'(KV);
  assign pv_c = PW'(sel_v) * PW'(KV);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) a_vld <= 1'b0;
    else         a_vld <= emit;
  end

  always_ff @(posedge clk) begin
    if (emit) begin
      a_fl    <= emit_fl;
      a_first <= sel_first;
      a_base  <= sel_base;
      a_pass  <= sel_pass;
      a_pu    <= pu_c;
      a_pv    <= pv_c;
    end
  end

  always_comb begin
    sum_c = SW'(a_pu) + SW'(a_pv);
    rnd_c = W'((sum_c + HALF) >>> FRAC);
    new_c = a_base + rnd_c;
    b_s_n = (KIND == STEP_PREDICT) ? a_pass : new_c;
    b_d_n = (KIND == STEP_PREDICT) ? new_c  : a_pass;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) out_vld <= 1'b0;
    else         out_vld <= a_vld;
  end

  always_ff @(posedge clk) begin
    if (a_vld) begin
      out_fl    <= a_fl;
      out_first <= a_first;
      out_s     <= b_s_n;
      out_d     <= b_d_n;
    end
  end

endmodule

// File: rtl/wl_scale.sv
module wl_scale #(
  parameter int W    = 16,
  parameter int CW   = 16,
  parameter int FRAC = 12,
  parameter int KLO  = 4096,
  parameter int KHI  = 4096
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                in_vld,
  input  logic signed [W-1:0] in_s,
  input  logic signed [W-1:0] in_d,
  output logic                out_vld,
  output logic signed [W-1:0] out_l,
  output logic signed [W-1:0] out_h
);

  localparam int PW = W + CW;
  localparam logic signed [CW-1:0] KL   = CW'(KLO);
  localparam logic signed [CW-1:0] KH   = CW'(KHI);
  localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC - 1);

  logic                 a_vld;
  logic signed [PW-1:0] a_pl, a_ph, pl_c, ph_c;
  logic signed [W-1:0]  l_c, h_c;

  assign pl_c = PW'(in_s) * PW'(KL);
  assign ph_c = PW'(in_d) * PW'(KH);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) a_vld <= 1'b0;
    else         a_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      a_pl <= pl_c;
      a_ph <= ph_c;
    end
  end

  always_comb begin
    l_c = W'((a_pl + HALF) >>> FRAC);
    h_c = W'((a_ph + HALF) >>> FRAC);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) out_vld <= 1'b0;
    else         out_vld <= a_vld;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      out_l <= '0;
      out_h <= '0;
    end else if (a_vld) begin
      out_l <= l_c;
      out_h <= h_c;
    end
  end

  // R8
  scale_follow_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    in_vld |=> ##1 out_vld);

endmodule

// File: rtl/wavelet_lift_fwd.sv
module wavelet_lift_fwd
  import wl_lift_pkg::*;
#(
  parameter int DW       = 12,
  parameter int GUARD    = 4,
  parameter int CW       = 16,
  parameter int FRAC     = 12,
  parameter int STEP0_K  = -6497,
  parameter int STEP1_K  = -217,
  parameter int STEP2_K  = 3616,
  parameter int STEP3_K  = 1817,
  parameter int STEP4_K  = -2458,
  parameter int STEP5_K  = 1229,
  parameter int SCALE_LO = 4710,
  parameter int SCALE_HI = 3562
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_start,
  input  logic                       in_flush,
  input  logic signed [DW-1:0]       in_even,
  input  logic signed [DW-1:0]       in_odd,
  output logic                       out_valid,
  output logic signed [DW+GUARD-1:0] out_low,
  output logic signed [DW+GUARD-1:0] out_high
);

  localparam int W     = DW + GUARD;
  localparam int NSTEP = LIFT_STEPS;

  function automatic int step_coef(input int i);
    case (i)
      0:       return STEP0_K;
      1:       return STEP1_K;
      2:       return STEP2_K;
      3:       return STEP3_K;
      4:       return STEP4_K;
      default: return STEP5_K;
    endcase
  endfunction

  // reset: asserted at once, released after two clock edges
  logic rst_meta, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // item chain between the lifting steps
  logic [NSTEP:0]      bv, bf, bfirst;
  logic signed [W-1:0] bs [NSTEP+1];
  logic signed [W-1:0] bd [NSTEP+1];

  always_comb begin
    bv[0]     = in_valid | in_flush;
    bf[0]     = in_flush;
    bfirst[0] = in_start & ~in_flush;
    bs[0]     = W'(in_even);
    bd[0]     = W'(in_odd);
  end

  generate
    for (genvar g = 0; g < NSTEP; g++) begin : g_step
      wl_lift_step #(
        .W    (W),
        .CW   (CW),
        .FRAC (FRAC),
        .COEF (step_coef(g)),
        .KIND ((g % 2 == 0) ? STEP_PREDICT : STEP_UPDATE)
      ) u_step (
        .clk       (clk),
        .rst_ni    (rst_q),
        .in_vld    (bv[g]),
        .in_fl     (bf[g]),
        .in_first  (bfirst[g]),
        .in_s      (bs[g]),
        .in_d      (bd[g]),
        .out_vld   (bv[g+1]),
        .out_fl    (bf[g+1]),
        .out_first (bfirst[g+1]),
        .out_s     (bs[g+1]),
        .out_d     (bd[g+1])
      );
    end
  endgenerate

  logic scale_in_vld;
  assign scale_in_vld = bv[NSTEP] & ~bf[NSTEP];

  wl_scale #(
    .W    (W),
    .CW   (CW),
    .FRAC (FRAC),
    .KLO  (SCALE_LO),
    .KHI  (SCALE_HI)
  ) u_scale (
    .clk     (clk),
    .rst_ni  (rst_q),
    .in_vld  (scale_in_vld),
    .in_s    (bs[NSTEP]),
    .in_d    (bd[NSTEP]),
    .out_vld (out_valid),
    .out_l   (out_low),
    .out_h   (out_high)
  );

  // R5
  start_not_flush_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bv[NSTEP] && bfirst[NSTEP]) |-> !bf[NSTEP]);

endmodule

// File: tb/wavelet_lift_fwd_test.sv
`timescale 1ns/1ps
module wavelet_lift_fwd_test;

  localparam int DW = 12;
  localparam int W  = 16;
  localparam int FRAC = 12;
  localparam longint KS [6] = '{-6497, -217, 3616, 1817, -2458, 1229};
  localparam longint KLO = 4710;
  localparam longint KHI = 3562;

  // sequence table: pairs, pattern (0 ramp,1 random,2 const,3 alternating),
  // idle cycles after each beat, flush beats, flush beats with in_valid high
  localparam int NSEQ = 7;
  localparam int T_M   [NSEQ] = '{8, 12, 10, 1, 16, 6, 2};
  localparam int T_PAT [NSEQ] = '{0, 1, 2, 3, 1, 1, 3};
  localparam int T_GAP [NSEQ] = '{0, 0, 2, 0, 1, 3, 0};
  localparam int T_NFL [NSEQ] = '{3, 3, 3, 3, 5, 3, 4};
  localparam int T_FV  [NSEQ] = '{0, 0, 0, 0, 0, 1, 1};

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_start, in_flush;
  logic signed [DW-1:0] in_even, in_odd;
  logic out_valid;
  logic signed [W-1:0] out_low, out_high;

  always #10 clk = ~clk;

  wavelet_lift_fwd uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_flush(in_flush), .in_even(in_even), .in_odd(in_odd),
    .out_valid(out_valid), .out_low(out_low), .out_high(out_high)
  );

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  longint xs [128];
  longint el [64];
  longint eh [64];
  longint gl [64];
  longint gh [64];
  int got_n = 0;
  longint seed = 7;

  always @(negedge clk) begin
    if (rst_n && out_valid && got_n < 64) begin
      gl[got_n] = longint'(out_low);
      gh[got_n] = longint'(out_high);
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic longint rnd(input longint p);
    return (p + (longint'(1) <<< (FRAC - 1))) >>> FRAC;
  endfunction

  function automatic longint next_rand();
    seed = (seed * 1103515245 + 12345) & 64'h7fffffff;
    return ((seed >>> 16) % 801) - 400;
  endfunction

  task automatic model(input int m);
    longint s [64];
    longint d [64];
    for (int i = 0; i < m; i++) begin
      s[i] = xs[2*i];
      d[i] = xs[2*i+1];
    end
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < m; i++) begin
        if (k % 2 == 0) begin
          longint nx = (i == m - 1) ? s[i] : s[i+1];
          d[i] = d[i] + rnd(KS[k] * (s[i] + nx));
        end else begin
          longint pv = (i == 0) ? d[i] : d[i-1];
          s[i] = s[i] + rnd(KS[k] * (pv + d[i]));
        end
      end
    end
    for (int i = 0; i < m; i++) begin
      el[i] = rnd(KLO * s[i]);
      eh[i] = rnd(KHI * d[i]);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 1'b0; in_start = 1'b0; in_flush = 1'b0;
    in_even = '0; in_odd = '0;
  endtask

  task automatic run_seq(input int t);
    int m = T_M[t];
    string tag;
    for (int k = 0; k < 2 * m; k++) begin
      case (T_PAT[t])
        0: xs[k] = k * 7 - 100;
        1: xs[k] = next_rand();
        2: xs[k] = 123;
        default: xs[k] = (k % 2 == 0) ? 300 : -250;
      endcase
    end
    model(m);
    got_n = 0;
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_flush = 1'b0; in_start = (i == 0);
      in_even = DW'(xs[2*i]); in_odd = DW'(xs[2*i+1]);
      for (int g = 0; g < T_GAP[t]; g++) begin
        @(negedge clk);
        idle_inputs();
      end
    end
    for (int f = 0; f < T_NFL[t]; f++) begin
      @(negedge clk);
      in_valid = T_FV[t][0]; in_flush = 1'b1; in_start = 1'b0;
      in_even = 12'sd999; in_odd = -12'sd777;   // junk must be ignored
    end
    @(negedge clk);
    idle_inputs();
    repeat (30) @(negedge clk);
    // R7: exactly one output per pair
    chk(got_n == m, $sformatf("R7 seq %0d output count", t), got_n, m);
    for (int i = 0; i < m && i < got_n; i++) begin
      if (m == 1)          tag = "R5 R6 single pair";
      else if (i == 0)     tag = "R5 left edge";
      else if (i == m - 1) tag = "R6 right edge";
      else                 tag = "R1 R2 R3 R4 interior";
      chk(gl[i] == el[i], $sformatf("%s seq %0d idx %0d low", tag, t, i), gl[i], el[i]);
      chk(gh[i] == eh[i], $sformatf("%s seq %0d idx %0d high", tag, t, i), gh[i], eh[i]);
      if (T_PAT[t] == 2) begin
        // R10: constant input gives position-independent results
        chk(gl[i] == gl[0], $sformatf("R10 seq %0d idx %0d low", t, i), gl[i], gl[0]);
        chk(gh[i] == gh[0], $sformatf("R10 seq %0d idx %0d high", t, i), gh[i], gh[0]);
      end
    end
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    bit early;
    rst_n = 1'b0;
    idle_inputs();
    repeat (4) @(negedge clk);
    // R9: low during reset
    chk(out_valid == 1'b0, "R9 out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid after reset", longint'(out_valid), 0);
    chk(got_n == 0, "R9 no output after reset", got_n, 0);

    for (int t = 0; t < NSEQ; t++) run_seq(t);

    // R8: latency from the beat that completes pair 0
    got_n = 0;
    early = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_flush = 1'b0; in_start = (i == 0);
      in_even = DW'(i * 10); in_odd = DW'(i * 5 - 3);
    end
    for (int c = 1; c <= 14; c++) begin
      @(negedge clk);
      if (c == 1) idle_inputs();
      if (c < 14 && out_valid) early = 1'b1;
      if (c == 14)
        chk(out_valid == 1'b1, "R8 out_valid at 14th edge", longint'(out_valid), 1);
    end
    chk(early == 1'b0, "R8 no early output", longint'(early), 0);
    for (int f = 0; f < 3; f++) begin
      @(negedge clk);
      in_flush = 1'b1;
    end
    @(negedge clk);
    idle_inputs();
    repeat (30) @(negedge clk);
    chk(got_n == 4, "R7 R8 drained count", got_n, 4);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule